// File: doc/BRIEF.md
# I2C Command-Word Front End

This block sits between a register bus and an I2C byte engine. Software writes one 32-bit command word that names a target register offset, a 3-bit device select, a direction bit and 16 bits of write data. The block freezes the word, sends one request to the engine, and then samples the engine's completion at a fixed polling interval. A finished transfer sets a ready flag in the same word. A read also places the returned byte in the low byte. If no completion has been seen after a bounded number of polls, the block raises a timeout flag.

A helper sequencer drives the same path for byte-sized accesses. It takes an 8-bit device address and derives the device select from address bits [3:1]. A byte read is a single read. A byte write is widened into a 16-bit read-modify-write: the helper reads offset+1, then writes {fetched byte, new byte} to the offset. If that first read fails, the helper abandons the write.

Control states: `C_IDLE`, `C_LAUNCH` (request pulse) and `C_WAIT` (polling). The transitions are C_IDLE→C_LAUNCH on an accepted command, C_LAUNCH→C_WAIT always, and C_WAIT→C_IDLE on a poll that sees an acknowledge or on the last poll. Helper states: `H_IDLE`, `H_FETCH`, `H_FETCH_WAIT`, `H_STORE`, `H_STORE_WAIT`, `H_LOOK`, `H_LOOK_WAIT` and `H_END`. A byte write runs H_IDLE→H_FETCH→H_FETCH_WAIT→H_STORE→H_STORE_WAIT→H_END. A byte read runs H_IDLE→H_LOOK→H_LOOK_WAIT→H_END. H_FETCH_WAIT goes directly to H_END if the fetch fails, and H_END always returns to H_IDLE.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: A bus write accepted while the block is idle loads bits [27:0] of the command word, clears the ready (bit 28), error (bit 29) and timeout (bit 30) flags, and issues exactly one single-cycle engine request carrying the word's offset [23:16], device select [26:24] and data [15:0].
- R2: Bit 27 selects the direction: 1 is a read and 0 is a write. The value appears on `eng_read`.
- R3: When a read completes, bit 28 is 1, bits [7:0] hold the byte returned by the engine, and bits [15:8] are 0.
- R4: When a write completes, bit 28 is 1 and the data field [15:0] keeps the written value.
- R5: If the engine acknowledges with `eng_err` high, the transfer completes with both bit 29 and bit 28 set.
- R6: Completion is sampled once every POLL_GAP cycles. If no acknowledge has been seen after POLL_LIMIT polls, the block sets bits 30 and 29, leaves bit 28 at 0, and becomes idle again. This happens between POLL_GAP*POLL_LIMIT and POLL_GAP*POLL_LIMIT+4 cycles after the command is accepted.
- R7: A bus write that arrives while a command is in flight, or while the helper is active, is ignored and produces no engine request.
- R8: A helper byte read uses bits [3:1] of `hlp_dev_addr` as the device select, reads `hlp_off`, and presents the byte on `hlp_rdata` while `hlp_done` pulses.
- R9: A helper byte write first reads offset+1 (wrapping modulo 256). It then writes the 16-bit value {fetched byte, `hlp_byte`} to the offset.
- R10: If the fetch read of a helper byte write fails, no write request is issued, `hlp_fail` is 1 during `hlp_done`, and bit 29 of the word is set.
- R11: If `hlp_start` and a bus write arrive in the same idle cycle, the helper is served and the bus write is dropped.
- R12: After reset the word reads 0x1000_0000 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Command word write strobe |
| reg_wdata | input | 32 | Command word write value |
| reg_rdata | output | 32 | Current command word with flags |
| hlp_start | input | 1 | Start a helper byte access |
| hlp_write | input | 1 | Helper direction, 1 = byte write |
| hlp_dev_addr | input | 8 | Helper 8-bit device address |
| hlp_off | input | 8 | Helper register offset |
| hlp_byte | input | 8 | Helper byte to write |
| hlp_done | output | 1 | Helper finished (one cycle) |
| hlp_fail | output | 1 | Helper access failed, valid with hlp_done |
| hlp_rdata | output | 8 | Helper read byte, valid with hlp_done |
| eng_req | output | 1 | Engine request pulse |
| eng_read | output | 1 | Engine direction, 1 = read |
| eng_dev | output | 3 | Engine device select |
| eng_off | output | 8 | Engine register offset |
| eng_wdata | output | 16 | Engine write data |
| eng_ack | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error, valid with eng_ack |
| eng_rdata | input | 8 | Engine read byte, valid with eng_ack |

## Verification
A helper start and a software command write can both arrive in the same idle cycle, because they compete for the single command path. The bench provokes this by raising `hlp_start` and `reg_wr` on the same falling edge, with different device selects. It then judges the outcome by the engine request count and the device field of the final word: exactly one request, for the helper's device. The bench also writes a command one cycle after launch, while the first is in flight, and checks that only the first request reaches the engine.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

    localparam int CMD_BITS  = 28;
    localparam int BIT_RDY   = 28;
    localparam int BIT_ERR   = 29;
    localparam int BIT_TMO   = 30;
    localparam logic OP_READ  = 1'b1;
    localparam logic OP_WRITE = 1'b0;

    typedef struct packed {
        logic        op;
        logic [2:0]  dev;
        logic [7:0]  off;
        logic [15:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_LAUNCH,
        C_WAIT
    } ctl_state_t;

    typedef enum logic [2:0] {
        H_IDLE,
        H_FETCH,
        H_FETCH_WAIT,
        H_STORE,
        H_STORE_WAIT,
        H_LOOK,
        H_LOOK_WAIT,
        H_END
    } seq_state_t;

endpackage

// File: rtl/i2cfe_poll_timer.sv
module i2cfe_poll_timer #(
    parameter int POLL_GAP   = 4,
    parameter int POLL_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic poll,
    output logic poll_last
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [GW-1:0] GAP_END = GW'(POLL_GAP - 1);
    localparam logic [CW-1:0] CNT_END = CW'(POLL_LIMIT - 1);

    logic [GW-1:0] gap_q;
    logic [CW-1:0] cnt_q;

    always_comb begin
        poll      = run && (gap_q == GAP_END);
        poll_last = poll && (cnt_q == CNT_END);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            cnt_q <= '0;
        end else if (!run || poll_last) begin
            gap_q <= '0;
            cnt_q <= '0;
        end else if (poll) begin
            gap_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(POLL_LIMIT));

endmodule

// File: rtl/i2cfe_cmd_ctrl.sv
module i2cfe_cmd_ctrl
    import i2cfe_pkg::*;
#(
    parameter int POLL_GAP   = 4,
    parameter int POLL_LIMIT = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_take,
    input  logic [31:0] bus_wdata,
    input  logic        seq_issue,
    input  cmd_t        seq_cmd,
    input  logic        eng_ack,
    input  logic        eng_err,
    input  logic [7:0]  eng_rdata,
    output logic [31:0] reg_word,
    output logic        eng_req,
    output cmd_t        eng_cmd,
    output logic        cmd_done,
    output logic        cmd_fail,
    output logic [7:0]  cmd_rbyte,
    output logic        ctl_idle
);
    ctl_state_t state_q, state_d;
    cmd_t       cmd_q;
    logic       ready_q, err_q, tmo_q;
    logic       ack_seen_q, err_seen_q;
    logic [7:0] rbyte_q;
    logic       poll, poll_last;
    logic       accept;

    i2cfe_poll_timer #(
        .POLL_GAP  (POLL_GAP),
        .POLL_LIMIT(POLL_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == C_WAIT),
        .poll     (poll),
        .poll_last(poll_last)
    );

    assign accept = (state_q == C_IDLE) && (seq_issue || bus_take);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:   if (seq_issue || bus_take) state_d = C_LAUNCH;
            C_LAUNCH: state_d = C_WAIT;
            C_WAIT:   if (poll && (ack_seen_q || poll_last)) state_d = C_IDLE;
            default:  state_d = C_IDLE;
        endcase
    end

    // word, flags and engine capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            ready_q    <= 1'b1;
            err_q      <= 1'b0;
            tmo_q      <= 1'b0;
            ack_seen_q <= 1'b0;
            err_seen_q <= 1'b0;
            rbyte_q    <= '0;
        end else begin
            if (accept) begin
                cmd_q      <= seq_issue ? seq_cmd : cmd_t'(bus_wdata[CMD_BITS-1:0]);
                ready_q    <= 1'b0;
                err_q      <= 1'b0;
                tmo_q      <= 1'b0;
                ack_seen_q <= 1'b0;
                err_seen_q <= 1'b0;
            end
            if ((state_q != C_IDLE) && eng_ack && !ack_seen_q) begin
                ack_seen_q <= 1'b1;
                err_seen_q <= eng_err;
                rbyte_q    <= eng_rdata;
            end
            if ((state_q == C_WAIT) && poll) begin
                if (ack_seen_q) begin
                    ready_q <= 1'b1;
                    err_q   <= err_seen_q;
                    if (cmd_q.op == OP_READ) cmd_q.data <= {8'h00, rbyte_q};
                end else if (poll_last) begin
                    tmo_q <= 1'b1;
                    err_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        eng_req   = (state_q == C_LAUNCH);
        eng_cmd   = cmd_q;
        cmd_done  = (state_q == C_WAIT) && poll && (ack_seen_q || poll_last);
        cmd_fail  = ack_seen_q ? err_seen_q : 1'b1;
        cmd_rbyte = rbyte_q;
        ctl_idle  = (state_q == C_IDLE);
        reg_word  = {1'b0, tmo_q, err_q, ready_q, cmd_q};
    end

    assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);
    assert_ready_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready_q && eng_req);
    assert_ready_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(ack_seen_q));
    assert_fields_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != C_IDLE) |=> $stable(cmd_q.off) && $stable(cmd_q.dev) && $stable(cmd_q.op));
    assert_tmo_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_q && tmo_q));

endmodule

// File: rtl/i2cfe_byte_seq.sv
module i2cfe_byte_seq
    import i2cfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wr,
    input  logic [7:0] dev_addr,
    input  logic [7:0] off,
    input  logic [7:0] byte_in,
    input  logic       ctl_idle,
    input  logic       cmd_done,
    input  logic       cmd_fail,
    input  logic [7:0] cmd_rbyte,
    output logic       seq_issue,
    output cmd_t       seq_cmd,
    output logic       seq_idle,
    output logic       done,
    output logic       fail,
    output logic [7:0] rdata
);
    seq_state_t st_q, st_d;
    logic [2:0] dsel_q;
    logic [7:0] off_q, byte_q, hi_q, rdata_q;
    logic       fail_q;
    logic       take;

    assign take = (st_q == H_IDLE) && start && ctl_idle;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= H_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            H_IDLE:       if (take) st_d = wr ? H_FETCH : H_LOOK;
            H_FETCH:      st_d = H_FETCH_WAIT;
            H_FETCH_WAIT: if (cmd_done) st_d = cmd_fail ? H_END : H_STORE;
            H_STORE:      st_d = H_STORE_WAIT;
            H_STORE_WAIT: if (cmd_done) st_d = H_END;
            H_LOOK:       st_d = H_LOOK_WAIT;
            H_LOOK_WAIT:  if (cmd_done) st_d = H_END;
            H_END:        st_d = H_IDLE;
            default:      st_d = H_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsel_q  <= '0;
            off_q   <= '0;
            byte_q  <= '0;
            hi_q    <= '0;
            rdata_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            if (take) begin
                dsel_q <= dev_addr[3:1];
                off_q  <= off;
                byte_q <= byte_in;
                fail_q <= 1'b0;
            end
            if (cmd_done) begin
                unique case (st_q)
                    H_FETCH_WAIT: begin hi_q <= cmd_rbyte; fail_q <= cmd_fail; end
                    H_STORE_WAIT: fail_q <= cmd_fail;
                    H_LOOK_WAIT:  begin rdata_q <= cmd_rbyte; fail_q <= cmd_fail; end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        seq_issue = 1'b0;
        seq_cmd   = '0;
        unique case (st_q)
            H_FETCH: begin
                seq_issue = 1'b1;
                seq_cmd   = '{op: OP_READ, dev: dsel_q, off: off_q + 8'd1, data: 16'h0000};
            end
            H_STORE: begin
                seq_issue = 1'b1;
                seq_cmd   = '{op: OP_WRITE, dev: dsel_q, off: off_q, data: {hi_q, byte_q}};
            end
            H_LOOK: begin
                seq_issue = 1'b1;
                seq_cmd   = '{op: OP_READ, dev: dsel_q, off: off_q, data: 16'h0000};
            end
            default: ;
        endcase
        seq_idle = (st_q == H_IDLE);
        done     = (st_q == H_END);
        fail     = fail_q;
        rdata    = rdata_q;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == H_FETCH_WAIT && cmd_done && cmd_fail) |=> (st_q == H_END) && !seq_issue);
    assert_issue_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_issue |-> ctl_idle);

endmodule

// File: rtl/i2c_cmd_frontend.sv
module i2c_cmd_frontend
    import i2cfe_pkg::*;
#(
    parameter int POLL_GAP   = 4,
    parameter int POLL_LIMIT = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hlp_start,
    input  logic        hlp_write,
    input  logic [7:0]  hlp_dev_addr,
    input  logic [7:0]  hlp_off,
    input  logic [7:0]  hlp_byte,
    output logic        hlp_done,
    output logic        hlp_fail,
    output logic [7:0]  hlp_rdata,
    output logic        eng_req,
    output logic        eng_read,
    output logic [2:0]  eng_dev,
    output logic [7:0]  eng_off,
    output logic [15:0] eng_wdata,
    input  logic        eng_ack,
    input  logic        eng_err,
    input  logic [7:0]  eng_rdata
);
    logic       seq_issue, seq_idle, ctl_idle;
    logic       cmd_done, cmd_fail;
    logic [7:0] cmd_rbyte;
    cmd_t       seq_cmd, eng_cmd;
    logic       bus_take;

    // helper start wins over a same-cycle bus write
    assign bus_take = reg_wr && seq_idle && !hlp_start;

    i2cfe_cmd_ctrl #(
        .POLL_GAP  (POLL_GAP),
        .POLL_LIMIT(POLL_LIMIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_take (bus_take),
        .bus_wdata(reg_wdata),
        .seq_issue(seq_issue),
        .seq_cmd  (seq_cmd),
        .eng_ack  (eng_ack),
        .eng_err  (eng_err),
        .eng_rdata(eng_rdata),
        .reg_word (reg_rdata),
        .eng_req  (eng_req),
        .eng_cmd  (eng_cmd),
        .cmd_done (cmd_done),
        .cmd_fail (cmd_fail),
        .cmd_rbyte(cmd_rbyte),
        .ctl_idle (ctl_idle)
    );

    i2cfe_byte_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (hlp_start),
        .wr       (hlp_write),
        .dev_addr (hlp_dev_addr),
        .off      (hlp_off),
        .byte_in  (hlp_byte),
        .ctl_idle (ctl_idle),
        .cmd_done (cmd_done),
        .cmd_fail (cmd_fail),
        .cmd_rbyte(cmd_rbyte),
        .seq_issue(seq_issue),
        .seq_cmd  (seq_cmd),
        .seq_idle (seq_idle),
        .done     (hlp_done),
        .fail     (hlp_fail),
        .rdata    (hlp_rdata)
    );

    always_comb begin
        eng_read  = eng_cmd.op;
        eng_dev   = eng_cmd.dev;
        eng_off   = eng_cmd.off;
        eng_wdata = eng_cmd.data;
    end

    assert_req_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !reg_rdata[BIT_RDY] && !reg_rdata[BIT_TMO]);
    assert_conflict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hlp_start && reg_wr && seq_idle && ctl_idle) |=> !eng_req);

endmodule

// File: tb/tb_i2c_cmd_frontend.sv
module tb_i2c_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hlp_start = 1'b0, hlp_write = 1'b0;
    logic [7:0]  hlp_dev_addr = '0, hlp_off = '0, hlp_byte = '0;
    logic        hlp_done, hlp_fail;
    logic [7:0]  hlp_rdata;
    logic        eng_req, eng_read;
    logic [2:0]  eng_dev;
    logic [7:0]  eng_off;
    logic [15:0] eng_wdata;
    logic        eng_ack = 1'b0, eng_err = 1'b0;
    logic [7:0]  eng_rdata = '0;

    localparam int GAP = 4;
    localparam int LIM = 100;

    always #2 clk = ~clk;

    i2c_cmd_frontend #(.POLL_GAP(GAP), .POLL_LIMIT(LIM)) dut (.*);

    int n_checks = 0, n_fail = 0;
    logic [7:0] dev_mem [0:2047];
    logic [7:0] ref_mem [0:2047];
    int req_count = 0;
    logic       lg_read [0:1];
    logic [2:0] lg_dev  [0:1];
    logic [7:0] lg_off  [0:1];
    logic [15:0] lg_wd  [0:1];

    function automatic logic [7:0] seed_byte(int i);
        return (8'(i) * 8'd7) ^ (8'(i >> 8) * 8'd29) ^ 8'h3C;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] d, logic [7:0] o, logic [7:0] b);
        return 32'h1800_0000 | (32'(d) << 24) | (32'(o) << 16) | 32'(b);
    endfunction

    function automatic logic [31:0] exp_write(logic [2:0] d, logic [7:0] o, logic [15:0] w);
        return 32'h1000_0000 | (32'(d) << 24) | (32'(o) << 16) | 32'(w);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // engine model: device 7 never answers, device 6 answers with an error
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                logic       rd;
                logic [2:0] dv;
                logic [7:0] of;
                logic [15:0] wd;
                rd = eng_read; dv = eng_dev; of = eng_off; wd = eng_wdata;
                lg_read[1] = lg_read[0]; lg_dev[1] = lg_dev[0];
                lg_off[1] = lg_off[0]; lg_wd[1] = lg_wd[0];
                lg_read[0] = rd; lg_dev[0] = dv; lg_off[0] = of; lg_wd[0] = wd;
                req_count++;
                if (dv != 3'd7) begin
                    repeat (($urandom % 16) + 1) @(negedge clk);
                    eng_ack = 1'b1;
                    eng_err = (dv == 3'd6);
                    eng_rdata = (dv == 3'd6) ? 8'h00 : dev_mem[{dv, of}];
                    if (!rd && dv != 3'd6) begin
                        dev_mem[{dv, of}] = wd[7:0];
                        dev_mem[{dv, 8'(of + 8'd1)}] = wd[15:8];
                    end
                    @(negedge clk);
                    eng_ack = 1'b0;
                    eng_err = 1'b0;
                end
            end
        end
    end

    task automatic bus_write(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_word(output int cyc);
        cyc = 0;
        while (!reg_rdata[28] && !reg_rdata[30] && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic helper(input logic w, input logic [7:0] a, input logic [7:0] o,
                          input logic [7:0] b);
        int c;
        @(negedge clk);
        hlp_start = 1'b1; hlp_write = w; hlp_dev_addr = a; hlp_off = o; hlp_byte = b;
        @(negedge clk);
        hlp_start = 1'b0;
        c = 0;
        while (!hlp_done && c < 3000) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        int cyc, rc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) begin
            dev_mem[i] = seed_byte(i);
            ref_mem[i] = seed_byte(i);
        end
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset word", reg_rdata, 32'h1000_0000);
        chk("R12 no request", 32'(eng_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R4 bus write
        bus_write(32'h0210_BEEF);
        chk("R1 ready cleared on accept", 32'(reg_rdata[28]), 32'd0);
        wait_word(cyc);
        chk("R1 request offset", 32'(lg_off[0]), 32'h10);
        chk("R1 request dev", 32'(lg_dev[0]), 32'd2);
        chk("R1 request data", 32'(lg_wd[0]), 32'hBEEF);
        chk("R2 write direction", 32'(lg_read[0]), 32'd0);
        chk("R4 write word", reg_rdata, exp_write(3'd2, 8'h10, 16'hBEEF));
        ref_mem[{3'd2, 8'h10}] = 8'hEF; ref_mem[{3'd2, 8'h11}] = 8'hBE;

        // R3 R2 bus reads
        bus_write(32'h0A11_5555);
        wait_word(cyc);
        chk("R2 read direction", 32'(lg_read[0]), 32'd1);
        chk("R3 read word upper", reg_rdata, exp_read(3'd2, 8'h11, ref_mem[{3'd2, 8'h11}]));
        bus_write(32'h0A10_0000);
        wait_word(cyc);
        chk("R3 read word lower", reg_rdata, exp_read(3'd2, 8'h10, ref_mem[{3'd2, 8'h10}]));

        // R5 engine error
        bus_write(32'h0E44_0000);
        wait_word(cyc);
        chk("R5 error word", reg_rdata, 32'h3E44_0000);

        // R6 timeout
        bus_write(32'h0F33_1234);
        wait_word(cyc);
        chk("R6 timeout word", reg_rdata, 32'h6F33_1234);
        chk("R6 timeout window", 32'((cyc + 1 >= GAP * LIM) && (cyc + 1 <= GAP * LIM + 4)), 32'd1);

        // R7 write while busy ignored
        rc = req_count;
        bus_write(32'h0905_0000);
        bus_write(32'h0B09_0000);
        wait_word(cyc);
        repeat (4) @(negedge clk);
        chk("R7 single request", 32'(req_count - rc), 32'd1);
        chk("R7 first command kept", reg_rdata, exp_read(3'd1, 8'h05, ref_mem[{3'd1, 8'h05}]));

        // R8 helper read, select from address bits [3:1]
        helper(1'b0, 8'hA4, 8'h7E, 8'h00);
        chk("R8 helper dev select", 32'(lg_dev[0]), 32'd2);
        chk("R8 helper read byte", 32'(hlp_rdata), 32'(ref_mem[{3'd2, 8'h7E}]));
        chk("R8 helper ok", 32'(hlp_fail), 32'd0);

        // R9 helper write with offset wrap
        rc = req_count;
        helper(1'b1, 8'h06, 8'hFF, 8'h5A);
        chk("R9 two requests", 32'(req_count - rc), 32'd2);
        chk("R9 fetch read", {lg_read[1], 20'(0), lg_dev[1], lg_off[1]}, {1'b1, 20'(0), 3'd3, 8'h00});
        chk("R9 store write", {lg_read[0], 12'(0), lg_dev[0], lg_off[0], lg_wd[0]},
            {1'b0, 12'(0), 3'd3, 8'hFF, ref_mem[{3'd3, 8'h00}], 8'h5A});
        ref_mem[{3'd3, 8'hFF}] = 8'h5A;

        // R10 failed fetch aborts
        rc = req_count;
        helper(1'b1, 8'h0C, 8'h20, 8'h11);
        chk("R10 helper fail", 32'(hlp_fail), 32'd1);
        chk("R10 no write issued", 32'(req_count - rc), 32'd1);
        chk("R10 error bit", 32'(reg_rdata[29]), 32'd1);

        // R11 same-cycle helper and bus write
        rc = req_count;
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h0C01_0000;
        hlp_start = 1'b1; hlp_write = 1'b0; hlp_dev_addr = 8'h02; hlp_off = 8'h40;
        @(negedge clk);
        reg_wr = 1'b0; hlp_start = 1'b0;
        cyc = 0;
        while (!hlp_done && cyc < 3000) begin @(negedge clk); cyc++; end
        repeat (4) @(negedge clk);
        chk("R11 one request", 32'(req_count - rc), 32'd1);
        chk("R11 helper served", reg_rdata, exp_read(3'd1, 8'h40, ref_mem[{3'd1, 8'h40}]));

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [2:0] d;
            logic [7:0] o, b;
            logic [15:0] w;
            int kind;
            d = 3'($urandom % 6); o = 8'($urandom); b = 8'($urandom);
            w = 16'($urandom); kind = $urandom % 4;
            case (kind)
                0: begin
                    bus_write({4'b0000, 1'b1, d, o, 16'h0});
                    wait_word(cyc);
                    chk("R3 random read", reg_rdata, exp_read(d, o, ref_mem[{d, o}]));
                end
                1: begin
                    bus_write({4'b0000, 1'b0, d, o, w});
                    wait_word(cyc);
                    chk("R4 random write", reg_rdata, exp_write(d, o, w));
                    ref_mem[{d, o}] = w[7:0]; ref_mem[{d, 8'(o + 8'd1)}] = w[15:8];
                end
                2: begin
                    helper(1'b0, (8'($urandom) & 8'hF1) | {4'h0, d, 1'b0}, o, 8'h00);
                    chk("R8 random helper read", 32'(hlp_rdata), 32'(ref_mem[{d, o}]));
                end
                default: begin
                    helper(1'b1, (8'($urandom) & 8'hF1) | {4'h0, d, 1'b0}, o, b);
                    chk("R9 random helper write", reg_rdata,
                        exp_write(d, o, {ref_mem[{d, 8'(o + 8'd1)}], b}));
                    ref_mem[{d, o}] = b;
                end
            endcase
        end
        finish_run();
    end

endmodule